// File: doc/BRIEF.md
# Controller Liveness Watchdog

This block checks that an external host controller is still alive and running its loop. Software turns it on through a register write. From then on a down-counter runs. The host must read register address 0x00 before the count runs out. If the host goes silent, the block latches a fault and reports it three ways: a status bit, an active-low pin, and a halt request to the power stage.

The fault stays latched until software writes 1 to a clear-fault field. Turning the watchdog off and on again does not remove it. A two-bit delay-select field picks one of four timeout lengths, each set by a parameter.

The block takes already-decoded register strobes as inputs. Serial framing and address decode sit outside it.

Top module: `ctrl_watchdog`

## Requirements
- R1: After reset the watchdog is disabled and the outputs are idle: status 0, fault pin 1, halt 0. No fault appears while the watchdog stays disabled.
- R2: Writing 1 to the enable field starts the timer. With no kicks, the fault is visible exactly TICKS_n cycles after the clock edge that latches the enable. n is the delay-select value, coded 0, 1, 2 or 3, which picks TICKS_0 to TICKS_3.
- R3: A read strobe with address 0x00 restarts the full interval. The next fault comes TICKS_n cycles after the edge that samples the read.
- R4: A kick read in the same cycle as the final count wins over expiry, and no fault is raised.
- R5: Read strobes with any address other than 0x00 do not change when the fault occurs.
- R6: On expiry, in the same cycle, the status bit goes to 1, the fault pin goes to 0 and halt goes to 1.
- R7: The fault is sticky. It holds through clear writes of value 0, through reads of 0x00, and through enable writes.
- R8: A clear write of value 1 releases status, pin and halt at the next edge. If the watchdog is still enabled, the timer restarts with a full TICKS_n interval from that edge.
- R9: Writing 0 to the enable field stops the timer and holds it at its reload value, so re-enabling gives a full interval. Disabling does not clear a latched fault. A clear written while disabled releases the fault and no new fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Register read strobe, one cycle |
| rd_addr_i | input | ADDR_W | Address of the register read |
| en_wr_i | input | 1 | Write strobe for the enable field |
| en_val_i | input | 1 | Value written to the enable field |
| dly_wr_i | input | 1 | Write strobe for the delay-select field |
| dly_val_i | input | 2 | Value written to the delay-select field |
| clr_wr_i | input | 1 | Write strobe for the clear-fault field |
| clr_val_i | input | 1 | Value written to the clear-fault field; only 1 clears |
| wd_fault_o | output | 1 | Latched watchdog fault status |
| wd_fault_no | output | 1 | Active-low watchdog fault pin |
| halt_o | output | 1 | Halt request to the power stage |

## Verification
The hardest case to reach is a kick that arrives in the very cycle the count hits its last value. The bench gets there by sweeping the kick offset over every cycle of every interval, from zero up to TICKS_n-1 cycles after the enable, using four small, distinct tick counts. A second hard case is the reload after a clear while still enabled. The bench leaves a fault latched, sends clear-0 writes, reads and enable writes that must not remove it, then clears it and times the next expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned DLY_W   = 2;
  localparam int unsigned NUM_SEL = 1 << DLY_W;

  typedef logic [DLY_W-1:0] dly_sel_t;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TICKS_0 = 1000,
  parameter int unsigned TICKS_1 = 4000,
  parameter int unsigned TICKS_2 = 16000,
  parameter int unsigned TICKS_3 = 64000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic             dly_wr_i,
  input  dly_sel_t         dly_val_i,
  output logic             en_o,
  output logic [CNT_W-1:0] reload_o
);
  localparam int unsigned TBL [NUM_SEL] = '{TICKS_0, TICKS_1, TICKS_2, TICKS_3};

  logic             en_q;
  dly_sel_t         dly_q;
  logic [CNT_W-1:0] tick_tbl [NUM_SEL];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_tbl
    assign tick_tbl[i] = CNT_W'(TBL[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dly_q <= '0;
    end else begin
      if (en_wr_i)  en_q  <= en_val_i;
      if (dly_wr_i) dly_q <= dly_val_i;
    end
  end

  assign en_o     = en_q;
  assign reload_o = tick_tbl[dly_q];
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q <= CNT_W'(1));
  assign expire_o  = run_i && !kick_i && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || kick_i || last_tick) begin
      cnt_q <= reload_i;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !kick_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_kick_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && kick_i) |=> (cnt_q == $past(reload_i)));

  p_hold_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/wdg_fault_latch.sv
module wdg_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  logic fault_q;

  // expiry wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fault_q <= 1'b0;
    else if (set_i)   fault_q <= 1'b1;
    else if (clr_i)   fault_q <= 1'b0;
  end

  assign fault_o = fault_q;

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> fault_q);

  p_fault_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !clr_i) |=> fault_q);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !fault_q);
endmodule

// File: rtl/ctrl_watchdog.sv
module ctrl_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned KICK_ADDR = 0,
  parameter int unsigned TICKS_0   = 1000,
  parameter int unsigned TICKS_1   = 4000,
  parameter int unsigned TICKS_2   = 16000,
  parameter int unsigned TICKS_3   = 64000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic              dly_wr_i,
  input  logic [1:0]        dly_val_i,
  input  logic              clr_wr_i,
  input  logic              clr_val_i,
  output logic              wd_fault_o,
  output logic              wd_fault_no,
  output logic              halt_o
);
  localparam int unsigned MAX_TICKS = max_of4(TICKS_0, TICKS_1, TICKS_2, TICKS_3);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             en;
  logic [CNT_W-1:0] reload;
  logic             kick;
  logic             clr;
  logic             expire;
  logic             fault;

  assign kick = rd_stb_i && (rd_addr_i == ADDR_W'(KICK_ADDR));
  assign clr  = clr_wr_i && clr_val_i;

  wdg_cfg_regs #(
    .CNT_W   (CNT_W),
    .TICKS_0 (TICKS_0),
    .TICKS_1 (TICKS_1),
    .TICKS_2 (TICKS_2),
    .TICKS_3 (TICKS_3)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_wr_i   (en_wr_i),
    .en_val_i  (en_val_i),
    .dly_wr_i  (dly_wr_i),
    .dly_val_i (dly_val_i),
    .en_o      (en),
    .reload_o  (reload)
  );

  wdg_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en && !fault),
    .kick_i   (kick),
    .reload_i (reload),
    .expire_o (expire)
  );

  wdg_fault_latch u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (expire),
    .clr_i   (clr),
    .fault_o (fault)
  );

  assign wd_fault_o  = fault;
  assign wd_fault_no = ~fault;
  assign halt_o      = fault;

  p_no_expire_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !expire);

  p_kick_blocks_expire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick && !fault && !clr) |=> !wd_fault_o);
endmodule

// File: tb/tb_ctrl_watchdog.sv
`timescale 1ns/1ps
module tb_ctrl_watchdog;
  localparam int ADDR_W = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_stb_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic              en_wr_i = 1'b0;
  logic              en_val_i = 1'b0;
  logic              dly_wr_i = 1'b0;
  logic [1:0]        dly_val_i = '0;
  logic              clr_wr_i = 1'b0;
  logic              clr_val_i = 1'b0;
  logic              wd_fault_o;
  logic              wd_fault_no;
  logic              halt_o;

  int checks = 0;
  int fails  = 0;
  int tk [4] = '{4, 6, 9, 13};

  always #2 clk_i = ~clk_i;

  ctrl_watchdog #(
    .ADDR_W  (ADDR_W),
    .TICKS_0 (4),
    .TICKS_1 (6),
    .TICKS_2 (9),
    .TICKS_3 (13)
  ) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_stb_i    (rd_stb_i),
    .rd_addr_i   (rd_addr_i),
    .en_wr_i     (en_wr_i),
    .en_val_i    (en_val_i),
    .dly_wr_i    (dly_wr_i),
    .dly_val_i   (dly_val_i),
    .clr_wr_i    (clr_wr_i),
    .clr_val_i   (clr_val_i),
    .wd_fault_o  (wd_fault_o),
    .wd_fault_no (wd_fault_no),
    .halt_o      (halt_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // outputs must agree with the expected fault level (R6)
  task automatic chk_out(string req, bit f);
    chk({req, " status"}, int'(wd_fault_o), int'(f));
    chk({req, " pin"},    int'(wd_fault_no), int'(!f));
    chk({req, " halt"},   int'(halt_o), int'(f));
  endtask

  task automatic wr_en(bit v);
    en_wr_i = 1'b1; en_val_i = v;
    @(negedge clk_i);
    en_wr_i = 1'b0; en_val_i = 1'b0;
  endtask

  task automatic wr_dly(int s);
    dly_wr_i = 1'b1; dly_val_i = 2'(s);
    @(negedge clk_i);
    dly_wr_i = 1'b0;
  endtask

  task automatic wr_clr(bit v);
    clr_wr_i = 1'b1; clr_val_i = v;
    @(negedge clk_i);
    clr_wr_i = 1'b0; clr_val_i = 1'b0;
  endtask

  task automatic rd(int a);
    rd_stb_i = 1'b1; rd_addr_i = ADDR_W'(a);
    @(negedge clk_i);
    rd_stb_i = 1'b0; rd_addr_i = '0;
  endtask

  task automatic wait_fault(output int n, input int lim);
    n = 0;
    while (!wd_fault_o && n < lim) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic park();
    wr_en(1'b0);
    wr_clr(1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: idle after reset, nothing while disabled
    chk_out("R1 reset", 1'b0);
    repeat (40) @(negedge clk_i);
    chk_out("R1 disabled idle", 1'b0);

    // R2 / R6 / R9: free-running expiry per delay select
    for (int s = 0; s < 4; s++) begin
      wr_dly(s);
      wr_en(1'b1);
      wait_fault(n, 100);
      chk($sformatf("R2 timeout sel=%0d", s), n, tk[s]);
      chk_out("R6 fault outputs", 1'b1);
      wr_en(1'b0);
      repeat (3) @(negedge clk_i);
      chk_out("R9 disable keeps fault", 1'b1);
      wr_clr(1'b1);
      chk_out("R9 clear while disabled", 1'b0);
      repeat (30) @(negedge clk_i);
      chk_out("R9 no fault after clear disabled", 1'b0);
    end

    // R3 / R4: kick at every offset, including the final count
    for (int s = 0; s < 4; s++) begin
      wr_dly(s);
      for (int k = 0; k < tk[s]; k++) begin
        wr_en(1'b1);
        repeat (k) @(negedge clk_i);
        rd(0);
        if (k == tk[s] - 1) chk_out("R4 kick on last count", 1'b0);
        else                chk_out("R3 no fault after kick", 1'b0);
        wait_fault(n, 100);
        chk($sformatf("R3 interval after kick sel=%0d k=%0d", s, k), n, tk[s]);
        park();
      end
    end

    // R5: non-zero addresses do not restart the timer
    wr_dly(1);
    for (int k = 0; k <= tk[1] - 2; k++) begin
      wr_en(1'b1);
      repeat (k) @(negedge clk_i);
      rd(k + 1);
      wait_fault(n, 100);
      chk($sformatf("R5 other address k=%0d", k), n, tk[1] - k - 1);
      park();
    end
    wr_en(1'b1);
    rd(7'h7f);
    rd(7'h40);
    wait_fault(n, 100);
    chk("R5 high addresses", n, tk[1] - 2);
    park();

    // R7 / R8: stickiness and reload after clear
    wr_dly(0);
    wr_en(1'b1);
    wait_fault(n, 100);
    chk("R2 timeout sel=0 again", n, tk[0]);
    wr_clr(1'b0);
    repeat (10) @(negedge clk_i);
    chk_out("R7 clear value 0 ignored", 1'b1);
    wr_en(1'b1);
    chk_out("R7 enable write keeps fault", 1'b1);
    rd(0);
    chk_out("R7 kick keeps fault", 1'b1);
    wr_clr(1'b1);
    chk_out("R8 clear releases", 1'b0);
    wait_fault(n, 100);
    chk("R8 full interval after clear", n, tk[0]);
    park();

    // R9: disable halts the count, re-enable gives full interval
    wr_dly(3);
    wr_en(1'b1);
    repeat (5) @(negedge clk_i);
    wr_en(1'b0);
    repeat (40) @(negedge clk_i);
    chk_out("R9 disabled no fault", 1'b0);
    wr_en(1'b1);
    wait_fault(n, 100);
    chk("R9 full interval after re-enable", n, tk[3]);
    wr_en(1'b0);
    chk_out("R9 disable keeps fault", 1'b1);
    wr_en(1'b1);
    chk_out("R7 re-enable keeps fault", 1'b1);
    park();
    chk_out("R9 parked", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule